// File: doc/BRIEF.md
# Long-Mode Entry Guard for Control-Register Writes

This block owns the mode-control state of a 64-bit capable processor model: the paging enable bit, the physical-address-extension enable bit, the long-mode enable bit, the hardware-maintained long-mode active bit and the page-table base register. An execution stage sends it at most one register write per clock, together with two facts about the current context: whether the code segment has its 64-bit (long) attribute set, and whether the task register points at a 16-bit task-state segment.

Every write is screened against the state held before the write and the proposed new value. If the write would leave the processor in an inconsistent mode, nothing changes and a one-cycle fault pulse with a numeric reason code is raised. Otherwise the write commits on the same clock edge. The long-mode active bit cannot be written. It rises when paging turns on while long-mode enable is set, and it falls when paging turns off.

Top module: `mode_entry_guard`

## Requirements
- R1: After the asynchronous reset `rst_ni` is released, `pg_o`, `pae_o`, `lme_o`, `lma_o`, `ptb_o`, `fault_o` and `fault_code_o` are all zero.
- R2: A write with `wr_valid_i`=1 and no failing check commits on the next rising edge. The select codes are: 0 = paging control (`wr_data_i[0]` = paging enable), 1 = extension control (`wr_data_i[0]` = address-extension enable), 2 = feature control (`wr_data_i[0]` = long-mode enable), 3 = page-table base.
- R3: `lma_o` becomes 1 only when a committed select-0 write turns paging from 0 to 1 while long-mode enable is 1. The other bits of a select-2 write (including bit 1) have no effect on `lma_o`.
- R4: A committed select-0 write with `wr_data_i[0]`=0 clears `lma_o` on the same edge that clears `pg_o`.
- R5: Check 1: a select-2 write whose bit 0 differs from the current long-mode enable while paging is on faults with code 1.
- R6: Check 2: a select-0 write that turns paging on while long-mode enable is 1 and address extension is 0 faults with code 2.
- R7: Check 3: a select-1 write with bit 0 = 0 while long mode is active faults with code 3.
- R8: Check 4: a select-0 write that turns paging on while long-mode enable is 1 and `cs_long_i`=1 faults with code 4.
- R9: Check 5: a select-0 write that turns paging on while long-mode enable is 1 and `tr_narrow_i`=1 faults with code 5.
- R10: A faulting write leaves all five state outputs unchanged.
- R11: When several checks fail on one write, `fault_code_o` gives the lowest-numbered one.
- R12: A committed select-3 write stores the full 64 bits if `lma_o` was 1 before the write. Otherwise it stores bits 31:0 and clears the upper 32 bits.
- R13: `fault_o` is 1 for exactly the one cycle after a faulting write, and `fault_code_o` is 0 whenever `fault_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Write request this cycle |
| wr_sel_i | input | 2 | Target register select (0 paging, 1 extension, 2 feature, 3 base) |
| wr_data_i | input | 64 | Write value |
| cs_long_i | input | 1 | Current code segment has its long attribute set |
| tr_narrow_i | input | 1 | Task register references a 16-bit task-state segment |
| pg_o | output | 1 | Paging enable |
| pae_o | output | 1 | Address-extension enable |
| lme_o | output | 1 | Long-mode enable |
| lma_o | output | 1 | Long-mode active |
| ptb_o | output | 64 | Page-table base |
| fault_o | output | 1 | General-protection fault pulse |
| fault_code_o | output | 3 | Lowest-numbered failing check, 0 if none |

## Verification
Two things can fall on one edge: a select-0 write that commits paging also sets or clears the long-mode active bit, and a single activation attempt can trip checks 2, 4 and 5 together. The bench sets up long-mode enable with address extension on or off and with the context inputs in every combination, then sends activation and deactivation writes. A reference model computes the expected code and state for each write, and every output is compared after each edge. Random writes with rare context flags reach the same coincidences many times over.

// File: rtl/mode_entry_pkg.sv
package mode_entry_pkg;
  typedef enum logic [1:0] {
    SEL_PAGING = 2'd0,
    SEL_EXT    = 2'd1,
    SEL_FEAT   = 2'd2,
    SEL_BASE   = 2'd3
  } wr_sel_e;

  localparam int unsigned NUM_CHECKS = 5;
  localparam int unsigned CODE_W     = 3;

  typedef enum logic [CODE_W-1:0] {
    FC_NONE     = 3'd0,
    FC_LME_PG   = 3'd1,
    FC_NO_PAE   = 3'd2,
    FC_PAE_DROP = 3'd3,
    FC_CS_LONG  = 3'd4,
    FC_TR_16    = 3'd5
  } fault_code_e;

  typedef struct packed {
    logic pg;
    logic pae;
    logic lme;
    logic lma;
  } mode_bits_t;
endpackage

// File: rtl/mode_entry_check.sv
module mode_entry_check
  import mode_entry_pkg::*;
(
  input  mode_bits_t                mode_i,
  input  logic                      wr_valid_i,
  input  logic [1:0]                wr_sel_i,
  input  logic                      wr_bit_i,
  input  logic                      cs_long_i,
  input  logic                      tr_narrow_i,
  output logic                      bad_o,
  output logic [CODE_W-1:0]         code_o
);
  logic [NUM_CHECKS:1] fail_vec;
  logic                activate;

  // paging turning on with long mode enabled
  assign activate = wr_valid_i && (wr_sel_i == SEL_PAGING) && !mode_i.pg
                    && wr_bit_i && mode_i.lme;

  always_comb begin
    fail_vec    = '0;
    fail_vec[1] = wr_valid_i && (wr_sel_i == SEL_FEAT) && mode_i.pg
                  && (wr_bit_i != mode_i.lme);
    fail_vec[2] = activate && !mode_i.pae;
    fail_vec[3] = wr_valid_i && (wr_sel_i == SEL_EXT) && mode_i.lma && !wr_bit_i;
    fail_vec[4] = activate && cs_long_i;
    fail_vec[5] = activate && tr_narrow_i;
  end

  // lowest index wins
  always_comb begin
    code_o = '0;
    for (int i = NUM_CHECKS; i >= 1; i--) begin
      if (fail_vec[i]) code_o = CODE_W'(i);
    end
  end

  assign bad_o = |fail_vec;
endmodule

// File: rtl/mode_entry_state.sv
module mode_entry_state
  import mode_entry_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LOW_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output mode_bits_t        mode_o,
  output logic [DATA_W-1:0] ptb_o
);
  localparam int unsigned HIGH_W = DATA_W - LOW_W;

  mode_bits_t        mode_q, mode_d;
  logic [DATA_W-1:0] ptb_q, ptb_d, ptb_legacy;

  generate
    if (HIGH_W > 0) begin : g_split
      assign ptb_legacy = {{HIGH_W{1'b0}}, wr_data_i[LOW_W-1:0]};
    end else begin : g_flat
      assign ptb_legacy = wr_data_i;
    end
  endgenerate

  always_comb begin
    mode_d = mode_q;
    ptb_d  = ptb_q;
    if (commit_i) begin
      unique case (wr_sel_i)
        SEL_PAGING: begin
          mode_d.pg = wr_data_i[0];
          if (!wr_data_i[0])                         mode_d.lma = 1'b0;
          else if (!mode_q.pg && mode_q.lme)         mode_d.lma = 1'b1;
        end
        SEL_EXT:  mode_d.pae = wr_data_i[0];
        SEL_FEAT: mode_d.lme = wr_data_i[0];
        SEL_BASE: ptb_d = mode_q.lma ? wr_data_i : ptb_legacy;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      ptb_q  <= '0;
    end else begin
      mode_q <= mode_d;
      ptb_q  <= ptb_d;
    end
  end

  assign mode_o = mode_q;
  assign ptb_o  = ptb_q;

  AST_LMA_NEEDS_PG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q.lma |-> mode_q.pg && mode_q.lme); // R4
  AST_LMA_NEEDS_PAE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q.lma |-> mode_q.pae); // R7
  AST_LME_FROZEN_IN_PG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q.pg |=> (!mode_q.pg || $stable(mode_q.lme))); // R5
  AST_LEGACY_BASE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && wr_sel_i == SEL_BASE && !mode_q.lma) |=> (ptb_q[DATA_W-1:LOW_W] == '0)); // R12
endmodule

// File: rtl/mode_entry_guard.sv
module mode_entry_guard
  import mode_entry_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LOW_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              cs_long_i,
  input  logic              tr_narrow_i,
  output logic              pg_o,
  output logic              pae_o,
  output logic              lme_o,
  output logic              lma_o,
  output logic [DATA_W-1:0] ptb_o,
  output logic              fault_o,
  output logic [2:0]        fault_code_o
);
  mode_bits_t        mode;
  logic              bad;
  logic [CODE_W-1:0] code;
  logic              fault_q;
  logic [CODE_W-1:0] code_q;

  mode_entry_check u_check (
    .mode_i      (mode),
    .wr_valid_i  (wr_valid_i),
    .wr_sel_i    (wr_sel_i),
    .wr_bit_i    (wr_data_i[0]),
    .cs_long_i   (cs_long_i),
    .tr_narrow_i (tr_narrow_i),
    .bad_o       (bad),
    .code_o      (code)
  );

  mode_entry_state #(.DATA_W(DATA_W), .LOW_W(LOW_W)) u_state (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .commit_i  (wr_valid_i && !bad),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .mode_o    (mode),
    .ptb_o     (ptb_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q <= 1'b0;
      code_q  <= '0;
    end else begin
      fault_q <= bad;
      code_q  <= bad ? code : '0;
    end
  end

  assign pg_o         = mode.pg;
  assign pae_o        = mode.pae;
  assign lme_o        = mode.lme;
  assign lma_o        = mode.lma;
  assign fault_o      = fault_q;
  assign fault_code_o = code_q;

  AST_FAULT_KEEPS_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_q |-> ($stable(mode) && $stable(ptb_o))); // R10
  AST_CODE_MATCHES_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_q == (code_q != '0)); // R13
  AST_CODE_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_q <= CODE_W'(NUM_CHECKS)); // R11
  AST_LMA_RISE_ON_PG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode.lma) |-> $rose(mode.pg)); // R3
endmodule

// File: tb/mode_entry_guard_tb.sv
module mode_entry_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [63:0] wr_data = '0;
  logic        cs_long = 1'b0;
  logic        tr_narrow = 1'b0;
  logic        pg, pae, lme, lma, fault;
  logic [63:0] ptb;
  logic [2:0]  fcode;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model
  bit          m_pg, m_pae, m_lme, m_lma;
  logic [63:0] m_ptb;

  always #10 clk = ~clk; // 50 MHz

  mode_entry_guard dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .cs_long_i(cs_long), .tr_narrow_i(tr_narrow),
    .pg_o(pg), .pae_o(pae), .lme_o(lme), .lma_o(lma), .ptb_o(ptb),
    .fault_o(fault), .fault_code_o(fcode)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int exp_code(int sel, bit b, bit cs, bit tr);
    bit act;
    act = (sel == 0) && !m_pg && b && m_lme;
    if (sel == 2 && m_pg && b != m_lme) return 1;
    if (act && !m_pae) return 2;
    if (sel == 1 && m_lma && !b) return 3;
    if (act && cs) return 4;
    if (act && tr) return 5;
    return 0;
  endfunction

  task automatic model_commit(int sel, logic [63:0] d);
    case (sel)
      0: begin
        if (!d[0]) m_lma = 0;
        else if (!m_pg && m_lme) m_lma = 1;
        m_pg = d[0];
      end
      1: m_pae = d[0];
      2: m_lme = d[0];
      default: m_ptb = m_lma ? d : {32'h0, d[31:0]};
    endcase
  endtask

  task automatic cmp_all(string req, int code);
    chk({req, " pg"}, 64'(pg), 64'(m_pg));
    chk({req, " pae"}, 64'(pae), 64'(m_pae));
    chk({req, " lme"}, 64'(lme), 64'(m_lme));
    chk({req, " lma"}, 64'(lma), 64'(m_lma));
    chk({req, " ptb"}, ptb, m_ptb);
    chk({req, " fault"}, 64'(fault), 64'(code != 0));
    chk({req, " code"}, 64'(fcode), 64'(code));
  endtask

  // drive at negedge, result sampled at following negedge
  task automatic do_wr(string req, int sel, logic [63:0] d, bit cs, bit tr);
    int code;
    code = exp_code(sel, d[0], cs, tr);
    wr_valid = 1; wr_sel = 2'(sel); wr_data = d; cs_long = cs; tr_narrow = tr;
    @(negedge clk);
    wr_valid = 0; cs_long = 0; tr_narrow = 0;
    if (code == 0) model_commit(sel, d);
    cmp_all(req, code);
  endtask

  task automatic idle(string req);
    @(negedge clk);
    cmp_all(req, 0);
  endtask

  initial begin
    m_pg = 0; m_pae = 0; m_lme = 0; m_lma = 0; m_ptb = '0;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cmp_all("R1 reset", 0);

    do_wr("R2 pae on", 1, 64'h1, 0, 0);
    do_wr("R3 lme on, bit1 ignored", 2, 64'h3, 0, 0);
    chk("R3 lma stays 0", 64'(lma), 64'h0);
    do_wr("R12 legacy base", 3, 64'hDEAD_BEEF_1234_5678, 0, 0);
    chk("R12 upper cleared", ptb, 64'h0000_0000_1234_5678);
    do_wr("R11 codes 4+5 -> 4", 0, 64'h1, 1, 1);
    chk("R8 code 4", 64'(fcode), 64'd4);
    chk("R10 pg held", 64'(pg), 64'h0);
    idle("R13 pulse ends");
    do_wr("R9 tr narrow", 0, 64'h1, 0, 1);
    chk("R9 code 5", 64'(fcode), 64'd5);
    do_wr("R3 activate", 0, 64'h1, 0, 0);
    chk("R3 lma set", 64'(lma), 64'h1);
    do_wr("R12 full base", 3, 64'hDEAD_BEEF_1234_5678, 0, 0);
    chk("R12 full", ptb, 64'hDEAD_BEEF_1234_5678);
    do_wr("R5 lme drop in pg", 2, 64'h0, 0, 0);
    chk("R5 code 1", 64'(fcode), 64'd1);
    do_wr("R7 pae drop in lma", 1, 64'h0, 0, 0);
    chk("R7 code 3", 64'(fcode), 64'd3);
    do_wr("R4 pg off", 0, 64'h0, 0, 0);
    chk("R4 lma cleared", 64'(lma), 64'h0);
    do_wr("R2 pae off", 1, 64'h0, 0, 0);
    do_wr("R11 codes 2+4+5 -> 2", 0, 64'h1, 1, 1);
    chk("R6 code 2", 64'(fcode), 64'd2);
    chk("R10 lme held", 64'(lme), 64'h1);
    do_wr("R2 legacy pg on", 2, 64'h0, 0, 0);
    do_wr("R2 legacy pg", 0, 64'h1, 0, 0);
    chk("R3 no lma without lme", 64'(lma), 64'h0);
    do_wr("R4 pg off", 0, 64'h0, 0, 0);

    for (int i = 0; i < 3000; i++) begin
      int sel;
      logic [63:0] d;
      sel = int'($urandom_range(0, 3));
      d = {$urandom, $urandom};
      if (sel != 3 && $urandom_range(0, 3) == 0) d[0] = ~d[0];
      do_wr("R2/R10 random", sel, d,
            $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0);
      if ($urandom_range(0, 9) == 0) idle("R13 random idle");
    end
    done = 1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule